// File: doc/BRIEF.md
# Cartridge RAM Save/Restore Sequencer

This block sits beside a banked cartridge mapper and gives its 256-byte work RAM a persistent backing copy. A program asks for a transfer by writing an operation code into the last RAM byte and then touching the mapper's trigger location. The block then copies the whole RAM into a 256-byte nonvolatile array, or back out of it, at one byte per clock. A real transfer takes much longer than that copy, so the block also holds the busy state for a fixed time measured in clock cycles.

Software polls the same trigger location to learn when the transfer is done. Every enabled read there returns the current bank's ROM byte with one flag bit replaced. The flag reads 1 while the transfer is pending and 0 on the first poll after the deadline. That poll also clears the operation code and returns the block to idle.

The work RAM itself lives inside the block. The mapper reaches it through a simple host port, which stalls while the copy is running. A separate erase command fills the nonvolatile array with zeros. The nonvolatile array has its own power-on reset, so its contents survive a mapper reset.

Top module: `rsv_seq`

## Requirements
- R1: An enabled trigger access while idle starts an operation, using RAM byte 255 as the code; its returned flag (bit 6) is 1.
- R2: Code 1 replaces all 256 RAM bytes with the nonvolatile array contents.
- R3: Code 2 copies all 256 RAM bytes into the nonvolatile array.
- R4: While an operation is pending, an enabled trigger access returns rom_byte with bit 6 set and all other bits unchanged.
- R5: A load lasts CLK_HZ/2000 cycles and a store lasts (CLK_HZ/1000)*101 cycles, counted from the starting edge. The first enabled trigger access once that count is reached does three things: it returns bit 6 as 0, it clears RAM byte 255, and it returns the block to idle.
- R6: Any other code has zero duration, so the next enabled trigger access completes it.
- R7: erase while idle sets all nonvolatile bytes to 0 in one cycle; erase while an operation is pending has no effect.
- R8: With trigger_enable low, trig_rdata equals rom_byte and a trigger access starts and completes nothing.
- R9: A copy moves one byte per clock, and host_stall is high for exactly 256 cycles. Host writes during the stall are dropped, and host reads during it return 0.
- R10: A host write updates RAM at the clock edge. A host read presents the addressed byte on host_rdata one cycle later and holds it until the next read.
- R11: rst_n clears the RAM to 0 and idles the sequencer, but leaves the nonvolatile array intact; por_n clears the nonvolatile array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low mapper reset (RAM and sequencer) |
| por_n | input | 1 | Active-low power-on reset for the nonvolatile array |
| trig_strobe | input | 1 | Access to the trigger location this cycle |
| trig_enable | input | 1 | High when the mapper is in its seven-bank layout and the bank is unlocked |
| rom_byte | input | W | ROM byte of the current bank at the trigger location |
| trig_rdata | output | W | Data returned for a trigger access |
| erase | input | 1 | Zero the nonvolatile array |
| host_en | input | 1 | Host RAM access this cycle |
| host_we | input | 1 | Host access is a write |
| host_addr | input | log2(DEPTH) | Host RAM address |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Registered host read data |
| host_stall | output | 1 | Copy running; host accesses are dropped |

## Verification
The bench builds the block with CLK_HZ set to 600 kHz. This makes a load last 300 cycles and a store 60,600 cycles. With these values a full store and several loads fit in one run, and each deadline can be probed one cycle early and exactly on time. The 300-cycle load still exceeds the 256-cycle copy, so the bench also polls while the stall is up and again in the waiting phase after it.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_COPY = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        XFER_NONE  = 2'd0,
        XFER_LOAD  = 2'd1,
        XFER_STORE = 2'd2
    } xfer_e;

    localparam int unsigned CODE_LOAD  = 1;
    localparam int unsigned CODE_STORE = 2;

endpackage

// File: rtl/rsv_store.sv
module rsv_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned W     = 8,
    parameter int unsigned TAP   = DEPTH - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata,
    output logic [W-1:0]             tap
);

    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = '0;
            end
        end else if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[raddr];
    assign tap   = mem_q[TAP];

endmodule

// File: rtl/rsv_timer.sv
module rsv_timer
    import rsv_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  xfer_e kind,
    input  logic  run,
    output logic  done
);

    localparam int unsigned LOAD_CYC  = CLK_HZ / 2000;
    localparam int unsigned STORE_CYC = (CLK_HZ / 1000) * 101;
    localparam int unsigned CW        = $clog2(STORE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] el;
        logic [CW-1:0] lim;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.el = '0;
            case (kind)
                XFER_LOAD:  tmr_d.lim = CW'(LOAD_CYC);
                XFER_STORE: tmr_d.lim = CW'(STORE_CYC);
                default:    tmr_d.lim = '0;
            endcase
        end else if (run && (tmr_q.el != CW'(STORE_CYC))) begin
            tmr_d.el = tmr_q.el + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = (tmr_q.el >= tmr_q.lim);

endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
    import rsv_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig_go,
    input  logic [W-1:0]             code,
    input  logic                     timer_done,
    output phase_e                   phase,
    output xfer_e                    xfer,
    output logic [$clog2(DEPTH)-1:0] idx,
    output logic                     start,
    output xfer_e                    start_kind,
    output logic                     finish,
    output logic                     busy_bit,
    output logic                     copying
);

    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        phase_e        ph;
        xfer_e         xf;
        logic [AW-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        if (code == W'(CODE_LOAD)) begin
            start_kind = XFER_LOAD;
        end else if (code == W'(CODE_STORE)) begin
            start_kind = XFER_STORE;
        end else begin
            start_kind = XFER_NONE;
        end
        start    = trig_go && (ctl_q.ph == PH_IDLE);
        finish   = trig_go && (ctl_q.ph == PH_WAIT) && timer_done;
        busy_bit = !((ctl_q.ph == PH_WAIT) && timer_done);

        ctl_d = ctl_q;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (start) begin
                    ctl_d.xf  = start_kind;
                    ctl_d.idx = '0;
                    ctl_d.ph  = (start_kind == XFER_NONE) ? PH_WAIT : PH_COPY;
                end
            end
            PH_COPY: begin
                if (ctl_q.idx == AW'(DEPTH - 1)) begin
                    ctl_d.ph = PH_WAIT;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            PH_WAIT: begin
                if (finish) begin
                    ctl_d.ph = PH_IDLE;
                    ctl_d.xf = XFER_NONE;
                end
            end
            default: begin
                ctl_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, xf: XFER_NONE, idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase   = ctl_q.ph;
    assign xfer    = ctl_q.xf;
    assign idx     = ctl_q.idx;
    assign copying = (ctl_q.ph == PH_COPY);

endmodule

// File: rtl/rsv_seq.sv
module rsv_seq
    import rsv_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 125_000_000,
    parameter int unsigned DEPTH    = 256,
    parameter int unsigned W        = 8,
    parameter int unsigned FLAG_BIT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     por_n,
    input  logic                     trig_strobe,
    input  logic                     trig_enable,
    input  logic [W-1:0]             rom_byte,
    output logic [W-1:0]             trig_rdata,
    input  logic                     erase,
    input  logic                     host_en,
    input  logic                     host_we,
    input  logic [$clog2(DEPTH)-1:0] host_addr,
    input  logic [W-1:0]             host_wdata,
    output logic [W-1:0]             host_rdata,
    output logic                     host_stall
);

    localparam int unsigned AW     = $clog2(DEPTH);
    localparam int unsigned OP_IDX = DEPTH - 1;

    logic          trig_go;
    phase_e        phase;
    xfer_e         xfer;
    logic [AW-1:0] idx;
    logic          start;
    xfer_e         start_kind;
    logic          finish;
    logic          busy_bit;
    logic          copying;
    logic          timer_done;

    logic [W-1:0]  op_code;
    logic [W-1:0]  ram_rdata;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [W-1:0]  ram_wdata;
    logic [AW-1:0] ram_raddr;

    logic [W-1:0]  nv_rdata;
    logic [W-1:0]  nv_tap_unused;
    logic          nv_we;
    logic          nv_clr;

    logic [W-1:0]  rd_d, rd_q;

    assign trig_go = trig_strobe && trig_enable;

    rsv_ctrl #(
        .DEPTH (DEPTH),
        .W     (W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_go    (trig_go),
        .code       (op_code),
        .timer_done (timer_done),
        .phase      (phase),
        .xfer       (xfer),
        .idx        (idx),
        .start      (start),
        .start_kind (start_kind),
        .finish     (finish),
        .busy_bit   (busy_bit),
        .copying    (copying)
    );

    rsv_timer #(
        .CLK_HZ (CLK_HZ)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .kind  (start_kind),
        .run   (phase != PH_IDLE),
        .done  (timer_done)
    );

    // RAM write port: copy-in, then completion clear, then host
    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = host_addr;
        ram_wdata = host_wdata;
        if (copying && (xfer == XFER_LOAD)) begin
            ram_we    = 1'b1;
            ram_waddr = idx;
            ram_wdata = nv_rdata;
        end else if (finish) begin
            ram_we    = 1'b1;
            ram_waddr = AW'(OP_IDX);
            ram_wdata = '0;
        end else if (host_en && host_we && !copying) begin
            ram_we = 1'b1;
        end
        ram_raddr = copying ? idx : host_addr;
        nv_we     = copying && (xfer == XFER_STORE);
        nv_clr    = erase && (phase == PH_IDLE);
    end

    rsv_store #(
        .DEPTH (DEPTH),
        .W     (W),
        .TAP   (OP_IDX)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata),
        .tap   (op_code)
    );

    rsv_store #(
        .DEPTH (DEPTH),
        .W     (W),
        .TAP   (OP_IDX)
    ) u_nv (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (nv_clr),
        .we    (nv_we),
        .waddr (idx),
        .wdata (ram_rdata),
        .raddr (idx),
        .rdata (nv_rdata),
        .tap   (nv_tap_unused)
    );

    always_comb begin
        rd_d = rd_q;
        if (host_en && !host_we) begin
            rd_d = copying ? '0 : ram_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        trig_rdata = rom_byte;
        if (trig_enable) begin
            trig_rdata[FLAG_BIT] = busy_bit;
        end
    end

    assign host_rdata = rd_q;
    assign host_stall = copying;

endmodule

// File: rtl/rsv_seq_chk.sv
module rsv_seq_chk
    import rsv_pkg::*;
#(
    parameter int unsigned DEPTH    = 256,
    parameter int unsigned W        = 8,
    parameter int unsigned FLAG_BIT = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         trig_strobe,
    input logic         trig_enable,
    input logic [W-1:0] rom_byte,
    input logic [W-1:0] trig_rdata,
    input logic         host_en,
    input logic         host_we,
    input logic [W-1:0] host_rdata,
    input logic         host_stall,
    input phase_e       phase
);

    localparam logic [W-1:0] KEEP = ~(W'(1) << FLAG_BIT);

    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (host_stall) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_START_FROM_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_stall) |-> $past(trig_strobe && trig_enable)); // R1

    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_strobe && trig_enable && host_stall) |-> trig_rdata[FLAG_BIT]); // R4

    AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_strobe && trig_enable) |-> (((trig_rdata ^ rom_byte) & KEEP) == '0)); // R4

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_strobe && trig_enable && !trig_rdata[FLAG_BIT]) |=> (phase == PH_IDLE)); // R5

    AST_GATED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_strobe && !trig_enable && phase == PH_IDLE) |=> (phase == PH_IDLE)); // R8

    AST_GATED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_enable |-> (trig_rdata == rom_byte)); // R8

    AST_STALL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stall && host_en && !host_we) |=> (host_rdata == '0)); // R9

    AST_STALL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_stall) |-> (run_q == 16'(DEPTH))); // R9

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !host_stall); // R9

endmodule

bind rsv_seq rsv_seq_chk #(
    .DEPTH    (DEPTH),
    .W        (W),
    .FLAG_BIT (FLAG_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_strobe (trig_strobe),
    .trig_enable (trig_enable),
    .rom_byte    (rom_byte),
    .trig_rdata  (trig_rdata),
    .host_en     (host_en),
    .host_we     (host_we),
    .host_rdata  (host_rdata),
    .host_stall  (host_stall),
    .phase       (phase)
);

// File: tb/rsv_seq_test.sv
module rsv_seq_test;

    localparam int HZ    = 600_000;
    localparam int LOAD  = HZ / 2000;
    localparam int STORE = (HZ / 1000) * 101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_n = 1'b0;
    logic       trig_strobe = 1'b0;
    logic       trig_enable = 1'b0;
    logic [7:0] rom_byte = 8'h00;
    logic [7:0] trig_rdata;
    logic       erase = 1'b0;
    logic       host_en = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_stall;

    always #4 clk = ~clk;

    rsv_seq #(.CLK_HZ(HZ)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_n       (por_n),
        .trig_strobe (trig_strobe),
        .trig_enable (trig_enable),
        .rom_byte    (rom_byte),
        .trig_rdata  (trig_rdata),
        .erase       (erase),
        .host_en     (host_en),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_stall  (host_stall)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R10";

    // behavioural reference state
    int m_ram [256];
    int m_nv  [256];
    int m_ph = 0;   // 0 idle, 1 copying, 2 waiting
    int m_el = 0;
    int m_lat = 0;
    int m_cnt = 0;
    int m_rd = 0;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        int    e_trig;
        int    rd_n;
        bit    started;
        string lbl;
        #1;
        check("R9", "host_stall", int'(host_stall), (m_ph == 1) ? 1 : 0);
        if (trig_strobe) begin
            if (!trig_enable) begin
                e_trig = rom_byte;
                lbl = "R8";
            end else if (m_ph == 2 && m_el >= m_lat) begin
                e_trig = rom_byte & 8'hBF;
                lbl = "R5";
            end else begin
                e_trig = rom_byte | 8'h40;
                lbl = (m_ph == 0) ? "R1" : "R4";
            end
            check(lbl, "trig_rdata", int'(trig_rdata), e_trig);
        end
        rd_n = m_rd;
        if (host_en && !host_we) rd_n = (m_ph == 1) ? 0 : m_ram[host_addr];
        if (host_en && host_we && m_ph != 1) m_ram[host_addr] = host_wdata;
        if (erase && m_ph == 0) begin
            for (int i = 0; i < 256; i++) m_nv[i] = 0;
        end
        started = 1'b0;
        if (trig_strobe && trig_enable) begin
            if (m_ph == 0) begin
                started = 1'b1;
                m_el = 0;
                if (m_ram[255] == 1) begin
                    for (int i = 0; i < 256; i++) m_ram[i] = m_nv[i];
                    m_ph = 1; m_cnt = 256; m_lat = LOAD;
                end else if (m_ram[255] == 2) begin
                    for (int i = 0; i < 256; i++) m_nv[i] = m_ram[i];
                    m_ph = 1; m_cnt = 256; m_lat = STORE;
                end else begin
                    m_ph = 2; m_lat = 0;
                end
            end else if (m_ph == 2 && m_el >= m_lat) begin
                m_ram[255] = 0;
                m_ph = 0;
            end
        end
        if (!started) begin
            if (m_ph == 1) begin
                m_cnt--;
                if (m_cnt == 0) m_ph = 2;
            end
            m_el++;
        end
        @(posedge clk);
        m_rd = rd_n;
        @(negedge clk);
        check(cur_req, "host_rdata", int'(host_rdata), m_rd);
    endtask

    task automatic do_reset(bit por);
        rst_n = 1'b0;
        if (por) por_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        por_n = 1'b1;
        for (int i = 0; i < 256; i++) begin
            m_ram[i] = 0;
            if (por) m_nv[i] = 0;
        end
        m_ph = 0; m_el = 0; m_lat = 0; m_rd = 0;
    endtask

    task automatic hwrite(int a, int d);
        host_en = 1'b1; host_we = 1'b1; host_addr = 8'(a); host_wdata = 8'(d);
        tick();
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(int a, string req);
        cur_req = req;
        host_en = 1'b1; host_we = 1'b0; host_addr = 8'(a);
        tick();
        host_en = 1'b0;
    endtask

    task automatic trig(bit en);
        trig_strobe = 1'b1; trig_enable = en;
        tick();
        trig_strobe = 1'b0; trig_enable = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // waits quietly, then polls every cycle from just before the deadline
    task automatic run_to_done();
        while (m_ph != 0) begin
            if (m_ph == 2 && m_el + 3 >= m_lat) trig(1'b1);
            else tick();
        end
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < 256; i++) hread(i, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        do_reset(1'b1);
        // R11: reset state
        hread(0, "R11");
        hread(255, "R11");
        rom_byte = 8'h3C;
        trig(1'b0);

        // R10: host writes and reads
        for (int i = 0; i < 255; i++) hwrite(i, (i * 7 + 3) & 8'hFF);
        hwrite(255, 2);
        hread(17, "R10");
        idle(2);
        hread(200, "R10");
        idle(1);

        // R8: gated trigger neither flags nor starts
        rom_byte = 8'h5A;
        trig(1'b0);
        idle(3);
        hread(255, "R8");

        // R3 store with R1 start, R4 polling, R9 blocking
        rom_byte = 8'h00;
        trig(1'b1);
        idle(10);
        trig(1'b1);
        hwrite(3, 8'hEE);
        hread(3, "R9");
        idle(5);
        rom_byte = 8'hFF;
        trig(1'b1);
        run_to_done();
        hread(255, "R5");
        hread(3, "R9");

        // R2 load restores the stored image
        for (int i = 0; i < 255; i++) hwrite(i, 8'h11);
        hwrite(255, 1);
        rom_byte = 8'hA5;
        trig(1'b1);
        idle(270);
        trig(1'b1);
        hwrite(10, 8'h77);
        run_to_done();
        read_all("R2");

        // R6: other code completes on the next poll; R7 erase ignored while pending
        hwrite(255, 5);
        rom_byte = 8'h40;
        trig(1'b1);
        erase = 1'b1;
        tick();
        erase = 1'b0;
        trig(1'b1);
        hread(255, "R6");
        hwrite(255, 0);
        trig(1'b1);
        trig(1'b1);
        hread(255, "R6");

        // R11: mapper reset keeps the backing copy
        hwrite(20, 8'h99);
        do_reset(1'b0);
        hread(20, "R11");
        hwrite(255, 1);
        trig(1'b1);
        run_to_done();
        read_all("R11");

        // R7: erase while idle, then load zeros
        erase = 1'b1;
        tick();
        erase = 1'b0;
        hwrite(255, 1);
        trig(1'b1);
        run_to_done();
        read_all("R7");

        report();
    end

endmodule